// File: doc/BRIEF.md
# Load/Store Address and Part-Word Unit

This unit sits in the memory stage of a 32-bit pipeline. For each memory operation it forms the effective address from a base register and an offset, and it can hand back an updated base value for the register file. It presents a word-aligned request with per-byte enables to a single-cycle synchronous data memory. On the cycle after a load it takes the returned word, moves the addressed byte or halfword down to bit 0, and widens it with zeros or with copies of its sign bit.

The offset comes either from a 16-bit immediate or from the result of a register-register operation computed upstream. A separate absolute form takes a 21-bit address instead. The operation stream is valid/ready: an operation is consumed in a cycle where `op_valid` and `op_ready` are both high. `op_ready` follows the memory's `mem_ready`, except for a rejected misaligned operation, which is always consumed. Upstream must hold the operation stable while `op_ready` is low. The memory request is valid/ready in the same way. Load data arrives one cycle after its request is accepted.

Top module: `lsu_unit`

## Requirements
- R1: Address mode bits `op_pre`,`op_wb` select the effective address: 00 and 01 use the base unchanged, 10 and 11 use base+offset. `mem_addr` is the effective address with its two low bits cleared.
- R2: When `op_wb`=1 on an accepted, non-absolute operation, `wb_valid` is high in that cycle and `wb_value` = base+offset. With `op_wb`=0, `wb_valid` stays low.
- R3: In the immediate form (`op_reg_form`=0) the 16-bit offset is sign-extended to 32 bits. In the register form, `op_reg_off` is used as it is.
- R4: The size field {`op_size_y`,`op_size_l`} decodes 01 to word, 00 to halfword, 10 to byte and 11 to word. Byte enables are 1<<ea[1:0] for a byte, 0011 or 1100 for a halfword (chosen by ea[1]), and 1111 for a word.
- R5: A register-form operation whose offset came from a shift (`op_reg_shift`=1) is always a word access, whatever the size field says.
- R6: Stores copy the low byte of `op_wdata` into every lane for a byte access and the low halfword into both halves for a halfword access. A word store passes `op_wdata` through unchanged.
- R7: One cycle after a load is accepted, `ld_valid` is high with `ld_rd` set to the load's destination. `ld_data` holds the addressed part moved to bit 0 and zero-extended (`op_zext`=1) or sign-extended (`op_zext`=0).
- R8: In the absolute form (`op_abs`=1) the address is the 21-bit `op_abs_addr` zero-extended with its two low bits cleared. The access is a word access and no writeback is made.
- R9: A halfword access with ea[0]=1 raises `align_err`, issues no memory request and makes no writeback. The operation is still consumed (`op_ready`=1).
- R10: While `mem_ready` is low, an aligned operation is not consumed (`op_ready`=0). In that case no writeback is made and no load result follows.
- R11: `ld_stall` is high in the load-return cycle when `nxt_rs1` or `nxt_rs2` equals the returning load's destination, and it is low otherwise.
- R12: After reset, `ld_valid` and `ld_stall` are low until a load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation consumed this cycle when high with op_valid |
| op_store | input | 1 | 1 = store, 0 = load |
| op_abs | input | 1 | Absolute 21-bit address form |
| op_reg_form | input | 1 | Offset taken from op_reg_off instead of op_imm |
| op_reg_shift | input | 1 | Register-form offset came from a shift; forces word size |
| op_pre | input | 1 | Use base+offset as the address |
| op_wb | input | 1 | Write base+offset back to the base register |
| op_size_y | input | 1 | Size field, upper bit |
| op_size_l | input | 1 | Size field, lower bit |
| op_zext | input | 1 | 1 = zero-extend load, 0 = sign-extend |
| op_base | input | 32 | Base register value |
| op_imm | input | 16 | Immediate offset |
| op_reg_off | input | 32 | Register-operation offset |
| op_abs_addr | input | 21 | Absolute address |
| op_wdata | input | 32 | Store source register |
| op_rd | input | 5 | Load destination register index |
| nxt_rs1 | input | 5 | First source index of the following instruction |
| nxt_rs2 | input | 5 | Second source index of the following instruction |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, valid the cycle after an accepted read |
| wb_valid | output | 1 | Base writeback strobe |
| wb_value | output | 32 | Base writeback value |
| align_err | output | 1 | Misaligned halfword rejected |
| ld_valid | output | 1 | Load result valid |
| ld_rd | output | 5 | Load result destination |
| ld_data | output | 32 | Aligned and extended load result |
| ld_stall | output | 1 | Load-use interlock request |

## Verification
Two functions meet in one cycle. A load returning from the previous cycle, with its lane shift, extension and possible interlock, lands in the same cycle as a new request that itself post-increments its base. The bench sets this up by issuing loads back to back with writeback enabled and with `nxt_rs1`/`nxt_rs2` pointing either at the returning destination or elsewhere. A behavioural model then compares the returned data, the new address and enables, the writeback value and the stall, all in that shared cycle. Back-pressure is mixed in during such a cycle, to show that a held operation neither writes back nor produces a later load result.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // size field {y,l}: 01 word, 00 half, 10 byte, 11 treated as word
  function automatic acc_size_e decode_size(input logic y, input logic l);
    case ({y, l})
      2'b00:   return SZ_HALF;
      2'b10:   return SZ_BYTE;
      default: return SZ_WORD;
    endcase
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int ABS_W = 21
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  reg_off,
  input  logic [ABS_W-1:0] abs_addr,
  input  logic             reg_form,
  input  logic             abs_mode,
  input  logic             pre,
  output logic [XLEN-1:0]  ea,
  output logic [XLEN-1:0]  sum
);
  logic [XLEN-1:0] offset;
  logic [ABS_W-1:0] abs_aligned;

  assign offset = reg_form ? reg_off : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign sum = base + offset;
  assign abs_aligned = abs_addr & ~ABS_W'(3);

  always_comb begin
    if (abs_mode)  ea = {{(XLEN-ABS_W){1'b0}}, abs_aligned};
    else if (pre)  ea = sum;
    else           ea = base;
  end
endmodule

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [$clog2(XLEN/8)-1:0] ea_lo,
  input  acc_size_e                 size,
  input  logic [XLEN-1:0]           wdata,
  output logic [XLEN/8-1:0]         be,
  output logic [XLEN-1:0]           lane_wdata,
  output logic                      misaligned
);
  localparam int LANES = XLEN / 8;
  localparam int LB    = $clog2(LANES);

  assign misaligned = (size == SZ_HALF) && ea_lo[0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LB-1:0] IDX = LB'(i);
    assign be[i] = (size == SZ_BYTE) ? (ea_lo == IDX) :
                   (size == SZ_HALF) ? (ea_lo[LB-1:1] == IDX[LB-1:1]) : 1'b1;
    assign lane_wdata[i*8 +: 8] = (size == SZ_BYTE) ? wdata[7:0] :
                                  (size == SZ_HALF) ? wdata[(i%2)*8 +: 8] :
                                                      wdata[i*8 +: 8];
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]           rdata,
  input  logic [$clog2(XLEN/8)-1:0] off,
  input  acc_size_e                 size,
  input  logic                      zext,
  output logic [XLEN-1:0]           data
);
  localparam int LB = $clog2(XLEN/8);

  logic [LB-1:0]   lane;
  logic [XLEN-1:0] shifted;

  always_comb begin
    case (size)
      SZ_BYTE: lane = off;
      SZ_HALF: lane = {off[LB-1:1], 1'b0};
      default: lane = '0;
    endcase
  end

  assign shifted = rdata >> {lane, 3'b000};

  always_comb begin
    case (size)
      SZ_BYTE: data = zext ? {{(XLEN-8){1'b0}}, shifted[7:0]}
                           : {{(XLEN-8){shifted[7]}}, shifted[7:0]};
      SZ_HALF: data = zext ? {{(XLEN-16){1'b0}}, shifted[15:0]}
                           : {{(XLEN-16){shifted[15]}}, shifted[15:0]};
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int ABS_W  = 21,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_store,
  input  logic              op_abs,
  input  logic              op_reg_form,
  input  logic              op_reg_shift,
  input  logic              op_pre,
  input  logic              op_wb,
  input  logic              op_size_y,
  input  logic              op_size_l,
  input  logic              op_zext,
  input  logic [XLEN-1:0]   op_base,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic [XLEN-1:0]   op_reg_off,
  input  logic [ABS_W-1:0]  op_abs_addr,
  input  logic [XLEN-1:0]   op_wdata,
  input  logic [RIDX_W-1:0] op_rd,
  input  logic [RIDX_W-1:0] nxt_rs1,
  input  logic [RIDX_W-1:0] nxt_rs2,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              wb_valid,
  output logic [XLEN-1:0]   wb_value,
  output logic              align_err,
  output logic              ld_valid,
  output logic [RIDX_W-1:0] ld_rd,
  output logic [XLEN-1:0]   ld_data,
  output logic              ld_stall
);
  localparam int LANES = XLEN / 8;
  localparam int LB    = $clog2(LANES);

  logic [XLEN-1:0] ea, sum;
  acc_size_e       acc_size;
  logic            misaligned, accept;

  // pending load state for the return cycle
  logic              pend_valid;
  logic [LB-1:0]     pend_off;
  acc_size_e         pend_size;
  logic              pend_zext;
  logic [RIDX_W-1:0] pend_rd;

  always_comb begin
    if (op_abs || (op_reg_form && op_reg_shift)) acc_size = SZ_WORD;
    else acc_size = decode_size(op_size_y, op_size_l);
  end

  lsu_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .ABS_W(ABS_W)) u_addr (
    .base     (op_base),
    .imm      (op_imm),
    .reg_off  (op_reg_off),
    .abs_addr (op_abs_addr),
    .reg_form (op_reg_form),
    .abs_mode (op_abs),
    .pre      (op_pre),
    .ea       (ea),
    .sum      (sum)
  );

  lsu_lane_ctrl #(.XLEN(XLEN)) u_lane (
    .ea_lo      (ea[LB-1:0]),
    .size       (acc_size),
    .wdata      (op_wdata),
    .be         (mem_be),
    .lane_wdata (mem_wdata),
    .misaligned (misaligned)
  );

  assign align_err = op_valid && misaligned;
  assign mem_valid = op_valid && !misaligned;
  assign op_ready  = mem_ready || misaligned;
  assign accept    = mem_valid && mem_ready;
  assign mem_we    = op_store;
  assign mem_addr  = {ea[XLEN-1:LB], {LB{1'b0}}};
  assign wb_valid  = accept && op_wb && !op_abs;
  assign wb_value  = sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_off   <= '0;
      pend_size  <= SZ_WORD;
      pend_zext  <= 1'b0;
      pend_rd    <= '0;
    end else begin
      pend_valid <= accept && !op_store;
      if (accept && !op_store) begin
        pend_off  <= ea[LB-1:0];
        pend_size <= acc_size;
        pend_zext <= op_zext;
        pend_rd   <= op_rd;
      end
    end
  end

  lsu_load_fmt #(.XLEN(XLEN)) u_fmt (
    .rdata (mem_rdata),
    .off   (pend_off),
    .size  (pend_size),
    .zext  (pend_zext),
    .data  (ld_data)
  );

  assign ld_valid = pend_valid;
  assign ld_rd    = pend_rd;
  assign ld_stall = pend_valid && ((nxt_rs1 == pend_rd) || (nxt_rs2 == pend_rd));
endmodule

// File: rtl/lsu_unit_checker.sv
module lsu_unit_checker #(
  parameter int XLEN  = 32,
  parameter int ABS_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic              op_abs,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN/8-1:0] mem_be,
  input logic              wb_valid,
  input logic              align_err,
  input logic              ld_valid,
  input logic              ld_stall
);
  assert_be_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be == '1) || ($countones(mem_be) inside {1, 2}));

  assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_valid && !wb_valid && op_ready));

  assert_wb_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (op_valid && mem_ready));

  assert_hold_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !mem_ready && !align_err) |-> !op_ready);

  assert_load_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_valid && mem_ready && !mem_we));

  assert_stall_on_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> ld_valid);

  assert_abs_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_abs && mem_valid) |-> (mem_be == '1 && mem_addr[XLEN-1:ABS_W] == '0));
endmodule

bind lsu_unit lsu_unit_checker #(.XLEN(XLEN), .ABS_W(ABS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_abs    (op_abs),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .wb_valid  (wb_valid),
  .align_err (align_err),
  .ld_valid  (ld_valid),
  .ld_stall  (ld_stall)
);

// File: tb/tb_lsu_unit.sv
`timescale 1ns/1ps
module tb_lsu_unit;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(HALF) clk = ~clk;

  logic        op_valid, op_ready, op_store, op_abs, op_reg_form, op_reg_shift;
  logic        op_pre, op_wb, op_size_y, op_size_l, op_zext;
  logic [31:0] op_base, op_reg_off, op_wdata;
  logic [15:0] op_imm;
  logic [20:0] op_abs_addr;
  logic [4:0]  op_rd, nxt_rs1, nxt_rs2;
  logic        mem_valid, mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        wb_valid, align_err, ld_valid, ld_stall;
  logic [31:0] wb_value, ld_data;
  logic [4:0]  ld_rd;

  lsu_unit dut (.*);

  logic [31:0] mem [16];
  int n_chk = 0;
  int n_fail = 0;

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:2]];
      end
    end
  end

  // model state for the load in flight
  logic        m_pend = 1'b0;
  logic [31:0] m_word;
  logic [1:0]  m_off;
  int          m_sz;
  logic        m_zext;
  logic [4:0]  m_rd;
  logic        n_pend;
  logic [31:0] n_word;
  logic [1:0]  n_off;
  int          n_sz;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt(input logic [31:0] w, input logic [1:0] off, input int sz, input logic z);
    logic [31:0] s;
    if (sz == 0) begin
      s = w >> (off * 8);
      return z ? {24'd0, s[7:0]} : {{24{s[7]}}, s[7:0]};
    end else if (sz == 1) begin
      s = w >> (off[1] * 16);
      return z ? {16'd0, s[15:0]} : {{16{s[15]}}, s[15:0]};
    end
    return w;
  endfunction

  task automatic step(input string scn);
    logic [31:0] off, sum, ea, ewd;
    logic [3:0]  ebe;
    int          sz;
    logic        err, mv, acc, wbv;
    #1;
    off = op_reg_form ? op_reg_off : {{16{op_imm[15]}}, op_imm};
    sum = op_base + off;
    if (op_abs) begin
      ea = {11'd0, op_abs_addr};
      ea[1:0] = 2'b00;
      sz = 2;
    end else begin
      ea = op_pre ? sum : op_base;
      if (op_reg_form && op_reg_shift) sz = 2;
      else if ({op_size_y, op_size_l} == 2'b00) sz = 1;
      else if ({op_size_y, op_size_l} == 2'b10) sz = 0;
      else sz = 2;
    end
    err = op_valid && (sz == 1) && ea[0];
    mv  = op_valid && !err;
    acc = mv && mem_ready;
    wbv = acc && op_wb && !op_abs;
    if (sz == 0) begin
      ebe = 4'b0001 << ea[1:0];
      ewd = {4{op_wdata[7:0]}};
    end else if (sz == 1) begin
      ebe = ea[1] ? 4'b1100 : 4'b0011;
      ewd = {2{op_wdata[15:0]}};
    end else begin
      ebe = 4'hF;
      ewd = op_wdata;
    end
    chk({scn, " R10"}, "op_ready", op_ready, mem_ready || err);
    chk({scn, " R9"}, "align_err", align_err, err);
    chk({scn, " R9"}, "mem_valid", mem_valid, mv);
    if (mv) begin
      chk({scn, " R1"}, "mem_addr", mem_addr, {ea[31:2], 2'b00});
      chk({scn, " R4"}, "mem_be", {28'd0, mem_be}, {28'd0, ebe});
      chk({scn, " R1"}, "mem_we", mem_we, op_store);
      if (op_store) chk({scn, " R6"}, "mem_wdata", mem_wdata, ewd);
    end
    chk({scn, " R2"}, "wb_valid", wb_valid, wbv);
    if (wbv) chk({scn, " R2"}, "wb_value", wb_value, sum);
    chk({scn, " R7"}, "ld_valid", ld_valid, m_pend);
    if (m_pend) begin
      chk({scn, " R7"}, "ld_data", ld_data, fmt(m_word, m_off, m_sz, m_zext));
      chk({scn, " R7"}, "ld_rd", {27'd0, ld_rd}, {27'd0, m_rd});
    end
    chk({scn, " R11"}, "ld_stall", ld_stall, m_pend && (nxt_rs1 == m_rd || nxt_rs2 == m_rd));
    n_pend = acc && !op_store;
    n_word = mem[ea[5:2]];
    n_off  = ea[1:0];
    n_sz   = sz;
    @(posedge clk);
    m_pend = n_pend;
    if (n_pend) begin
      m_word = n_word; m_off = n_off; m_sz = n_sz; m_zext = op_zext; m_rd = op_rd;
    end
    @(negedge clk);
  endtask

  task automatic clr();
    op_valid = 0; op_store = 0; op_abs = 0; op_reg_form = 0; op_reg_shift = 0;
    op_pre = 0; op_wb = 0; op_size_y = 0; op_size_l = 1; op_zext = 0;
    op_base = 0; op_imm = 0; op_reg_off = 0; op_abs_addr = 0; op_wdata = 0;
    op_rd = 0; nxt_rs1 = 5'd30; nxt_rs2 = 5'd30; mem_ready = 1;
  endtask

  task automatic ld(input logic [31:0] base, input logic [15:0] imm, input logic p, input logic q,
                    input logic y, input logic l, input logic z, input logic [4:0] rd);
    clr();
    op_valid = 1; op_base = base; op_imm = imm; op_pre = p; op_wb = q;
    op_size_y = y; op_size_l = l; op_zext = z; op_rd = rd;
  endtask

  initial begin
    #(HALF * 2.0 * 150000.0);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h8F7E6D5C + i * 32'h11213141;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: idle after reset
    step("R12"); step("R12");
    // R1/R2: the four address modes, word loads
    ld(32'd8, 16'd4, 0, 0, 0, 1, 0, 5'd1); step("R1 mode00");
    ld(32'd8, 16'd4, 0, 1, 0, 1, 0, 5'd2); step("R1 mode01");
    ld(32'd8, 16'd4, 1, 0, 0, 1, 0, 5'd3); step("R1 mode10");
    ld(32'd8, 16'd4, 1, 1, 0, 1, 0, 5'd4); step("R2 mode11");
    // R3: negative immediate
    ld(32'd40, 16'hFFF8, 1, 1, 0, 1, 0, 5'd5); step("R3 negimm");
    clr(); step("R3 drain");
    // R4/R7: byte and halfword loads on every lane, both extensions
    for (int k = 0; k < 4; k++) begin
      ld(32'd16, 16'(k), 1, 0, 1, 0, 0, 5'd6); step("R4 byte sext");
      ld(32'd20, 16'(k), 1, 0, 1, 0, 1, 5'd6); step("R7 byte zext");
    end
    for (int k = 0; k < 2; k++) begin
      ld(32'd24, 16'(k * 2), 1, 0, 0, 0, 0, 5'd8); step("R4 half sext");
      ld(32'd28, 16'(k * 2), 1, 0, 0, 0, 1, 5'd8); step("R7 half zext");
    end
    // R4: size code 11 treated as word
    ld(32'd12, 16'd0, 0, 0, 1, 1, 0, 5'd9); step("R4 code11");
    // R6: part-word stores, then read back
    clr(); op_valid = 1; op_store = 1; op_base = 32'd5; op_size_y = 1; op_size_l = 0;
    op_wdata = 32'h123456A5; step("R6 byte store");
    clr(); op_valid = 1; op_store = 1; op_base = 32'd10; op_size_y = 0; op_size_l = 0;
    op_wdata = 32'hDEAD8001; step("R6 half store");
    clr(); op_valid = 1; op_store = 1; op_base = 32'd60; op_wdata = 32'hCAFEF00D; step("R6 word store");
    ld(32'd4, 16'd0, 0, 0, 0, 1, 0, 5'd10); step("R6 readback");
    ld(32'd8, 16'd2, 1, 0, 0, 0, 0, 5'd11); step("R6 readback half");
    // R9: misaligned halfword, with writeback requested
    ld(32'd7, 16'd0, 0, 1, 0, 0, 0, 5'd12); step("R9 misaligned");
    ld(32'd6, 16'd1, 1, 1, 0, 0, 1, 5'd12); step("R9 misaligned pre");
    // R5: shift-derived register offset forces word
    clr(); op_valid = 1; op_reg_form = 1; op_reg_shift = 1; op_base = 32'd16; op_reg_off = 32'd5;
    op_pre = 1; op_size_y = 1; op_size_l = 0; op_rd = 5'd13; step("R5 shift word");
    clr(); op_valid = 1; op_reg_form = 1; op_base = 32'd16; op_reg_off = 32'd3;
    op_pre = 1; op_wb = 1; op_size_y = 1; op_size_l = 0; op_rd = 5'd14; step("R3 regform byte");
    // R8: absolute form, writeback ignored
    clr(); op_valid = 1; op_abs = 1; op_abs_addr = 21'h1FFF27; op_wb = 1; op_pre = 1;
    op_size_y = 1; op_size_l = 0; op_rd = 5'd15; step("R8 abs load");
    clr(); op_valid = 1; op_abs = 1; op_store = 1; op_abs_addr = 21'h000031; op_wdata = 32'h01020304;
    step("R8 abs store");
    // R10: memory busy holds the operation
    ld(32'd32, 16'd4, 0, 1, 0, 1, 0, 5'd16); mem_ready = 0; step("R10 busy");
    ld(32'd32, 16'd4, 0, 1, 0, 1, 0, 5'd16); mem_ready = 0; step("R10 busy2");
    ld(32'd33, 16'd0, 0, 0, 0, 0, 0, 5'd16); mem_ready = 0; step("R10 busy err");
    ld(32'd32, 16'd4, 0, 1, 0, 1, 0, 5'd16); step("R10 go");
    // R11: back-to-back loads with post-increment and interlock
    ld(32'd0, 16'd4, 0, 1, 1, 0, 0, 5'd7); step("R11 first");
    ld(32'd4, 16'd4, 0, 1, 1, 0, 1, 5'd9); nxt_rs1 = 5'd7; step("R11 hit rs1");
    ld(32'd8, 16'd2, 0, 1, 0, 0, 0, 5'd3); nxt_rs2 = 5'd9; step("R11 hit rs2");
    ld(32'd12, 16'd4, 0, 1, 0, 1, 0, 5'd4); nxt_rs1 = 5'd1; nxt_rs2 = 5'd2; step("R11 miss");
    ld(32'd16, 16'd4, 0, 1, 0, 1, 0, 5'd5); nxt_rs1 = 5'd4; mem_ready = 0; step("R11 hit busy");
    clr(); nxt_rs1 = 5'd5; step("R11 none after busy");
    clr(); step("R12 idle end");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule